// File: doc/BRIEF.md
# Type-A Tag Response Modulator (Manchester on an On-Off-Keyed Subcarrier)

This block produces the tag-to-reader response of a contactless tag running at the 106 kb/s type-A rate. Its only clock is the recovered 13.56 MHz carrier. Every register updates on the falling carrier edge, and all response timing is counted from that edge. The bit period is 128 carrier cycles. The subcarrier is a square wave of carrier/16, taken from bit 3 of the same phase counter.

Bytes arrive on a valid/ready handshake, and the block frames them. A frame opens with a start bit coded as logic 1. Each byte follows, sent least-significant bit first, and each byte is followed by an odd-parity bit. The frame closes with one silent bit period. Each bit is Manchester coded by placing four whole subcarrier periods in either the first or the second 64-cycle half of the bit. The result is a single load-modulation output, `mod_out`. CRC bytes, if any are wanted, are fed in as ordinary data.

The control path is a five-state machine:

| State | Role |
|---|---|
| `FS_IDLE` | Output low, ready high |
| `FS_SOF` | Start bit |
| `FS_DATA` | Eight data bits |
| `FS_PAR` | Parity bit |
| `FS_EOF` | Silent end bit |

Its transitions are:

| Transition | Condition |
|---|---|
| IDLE→SOF | A byte is accepted |
| SOF→DATA | End of the start bit |
| DATA→PAR | End of the eighth data bit |
| PAR→DATA | Another byte is accepted at the byte boundary |
| PAR→EOF | `tx_valid` is low at the byte boundary |
| EOF→IDLE | End of the silent bit |
| any→IDLE | Synchronous reset |

Top module: `nfcm_tx`

## Requirements
- R1: While `rst_n` is low at a falling clock edge, the block returns to idle. After that edge `mod_out` is 0 and `tx_ready` is 1.
- R2: In idle with `tx_valid` low, `mod_out` stays 0 and `tx_ready` stays 1, whatever `tx_data` carries.
- R3: A frame begins on the carrier cycle right after a byte is accepted. It opens with a start bit coded as logic 1, and every bit lasts exactly 128 carrier cycles.
- R4: A logic 1 bit carries subcarrier in cycles 0–63 of its bit period. A logic 0 bit carries subcarrier in cycles 64–127.
- R5: The subcarrier has a period of 16 carrier cycles. It is low for cycles 0–7 and high for cycles 8–15, counted from the start of the frame, so an active half holds 4 whole periods. During the inactive half of a bit, `mod_out` is 0.
- R6: The 8 data bits of a byte are sent least-significant bit first.
- R7: Each byte is followed by one parity bit that makes the count of ones over the 8 data bits plus the parity bit odd.
- R8: `tx_ready` is 1 only in idle and in the last carrier cycle of a parity bit. A byte is taken on a falling edge where `tx_valid` and `tx_ready` are both 1. `tx_data` at any other time has no effect on the output.
- R9: If `tx_valid` is high at the end of a parity bit, the next byte's first data bit follows at once, with no gap and no new start bit.
- R10: If `tx_valid` is low at the end of a parity bit, one 128-cycle bit with `mod_out` at 0 follows. The block is then idle with `tx_ready` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered carrier clock; all state updates on its falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_valid | input | 1 | A byte is offered on `tx_data` |
| tx_data | input | 8 | Byte to send, least-significant bit first |
| tx_ready | output | 1 | Block takes the offered byte on the next falling edge |
| mod_out | output | 1 | Load-modulation drive: Manchester-coded, on-off-keyed subcarrier |

## Verification
The output depends only on registers. When a byte is accepted on a falling edge, the sample at the next rising edge shows cycle 0 of the start bit, and the sample at the j-th rising edge after that shows cycle j mod 128 of bit j/128. The bench walks a cycle index from the handshake. It compares `mod_out` and `tx_ready` on every rising edge against a bit list built from the bytes it sent. It changes `tx_data` on the rising edge after each acceptance, so any mistimed capture of a byte shows up as wrong data bits. One rising edge after the last cycle of the silent bit, it checks for the idle state. One rising edge after a reset edge, it checks for the reset state.

// File: rtl/nfcm_pkg.sv
package nfcm_pkg;

    // Frame sequencer states
    typedef enum logic [2:0] {
        FS_IDLE,
        FS_SOF,
        FS_DATA,
        FS_PAR,
        FS_EOF
    } fs_t;

endpackage

// File: rtl/nfcm_divider.sv
// Carrier divider: one free phase counter per bit period, zeroed while idle.
// Its top bit selects the Manchester half; bit SUB_LOG2-1 is the subcarrier.
module nfcm_divider #(
    parameter int BIT_LOG2 = 7,
    parameter int SUB_LOG2 = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    output logic                bit_last,
    output logic                second_half,
    output logic                sub_level
);

    localparam logic [BIT_LOG2-1:0] PH_MAX = {BIT_LOG2{1'b1}};

    logic [BIT_LOG2-1:0] phase;

    always_ff @(negedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (run) begin
            phase <= phase + 1'b1;
        end else begin
            phase <= '0;
        end
    end

    assign bit_last    = run && (phase == PH_MAX);
    assign second_half = phase[BIT_LOG2-1];
    assign sub_level   = phase[SUB_LOG2-1];

    // Subcarrier phase restarts with every frame
    AST_PHASE_AT_FRAME_START: assert property (@(negedge clk) disable iff (!rst_n)
        $rose(run) |-> (phase == '0)); // R5

    // A running count keeps stepping by one carrier cycle
    AST_PHASE_STEPS: assert property (@(negedge clk) disable iff (!rst_n)
        (run && $past(run) && $past(rst_n)) |-> (phase == $past(phase) + 1'b1)); // R3

endmodule

// File: rtl/nfcm_framer.sv
// Frame sequencer: start bit, LSB-first data, odd parity, silent end bit.
module nfcm_framer
    import nfcm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              bit_last,
    output logic              in_ready,
    output logic              busy,
    output logic              silent,
    output logic              cur_bit
);

    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

    fs_t               state, nxt;
    logic [DATA_W-1:0] shreg;
    logic              par_acc;
    logic [CNT_W-1:0]  bit_idx;
    logic              take;

    assign take = in_valid && in_ready;

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            FS_IDLE: if (take) nxt = FS_SOF;
            FS_SOF:  if (bit_last) nxt = FS_DATA;
            FS_DATA: if (bit_last && bit_idx == LAST_IDX) nxt = FS_PAR;
            FS_PAR:  if (bit_last) nxt = take ? FS_DATA : FS_EOF;
            FS_EOF:  if (bit_last) nxt = FS_IDLE;
        endcase
    end

    // State register
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            state <= FS_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Byte shifter and parity accumulator
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            par_acc <= 1'b0;
            bit_idx <= '0;
        end else if (take) begin
            shreg   <= in_data;
            par_acc <= 1'b1;
            bit_idx <= '0;
        end else if (state == FS_DATA && bit_last) begin
            shreg   <= shreg >> 1;
            par_acc <= par_acc ^ shreg[0];
            bit_idx <= bit_idx + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        in_ready = 1'b0;
        busy     = 1'b1;
        silent   = 1'b0;
        cur_bit  = 1'b0;
        unique case (state)
            FS_IDLE: begin
                in_ready = 1'b1;
                busy     = 1'b0;
                silent   = 1'b1;
            end
            FS_SOF:  cur_bit = 1'b1;
            FS_DATA: cur_bit = shreg[0];
            FS_PAR: begin
                cur_bit  = par_acc;
                in_ready = bit_last;
            end
            FS_EOF:  silent = 1'b1;
        endcase
    end

    AST_SOF_AFTER_TAKE: assert property (@(negedge clk) disable iff (!rst_n)
        (state == FS_IDLE && in_valid) |=> (state == FS_SOF)); // R3

    AST_PAR_AFTER_BYTE: assert property (@(negedge clk) disable iff (!rst_n)
        (state == FS_DATA && bit_last && bit_idx == LAST_IDX) |=> (state == FS_PAR)); // R7

    AST_HOLD_BYTE: assert property (@(negedge clk) disable iff (!rst_n)
        (state == FS_DATA && !bit_last) |=> $stable(shreg)); // R8

    AST_NO_SOF_MIDFRAME: assert property (@(negedge clk) disable iff (!rst_n)
        (state == FS_PAR && bit_last && in_valid) |=> (state == FS_DATA)); // R9

    AST_EOF_TO_IDLE: assert property (@(negedge clk) disable iff (!rst_n)
        (state == FS_EOF && bit_last) |=> (state == FS_IDLE)); // R10

endmodule

// File: rtl/nfcm_coder.sv
// Manchester placement and on-off keying of the subcarrier.
module nfcm_coder (
    input  logic silent,
    input  logic cur_bit,
    input  logic second_half,
    input  logic sub_level,
    output logic mod_out
);

    logic half_active;

    // A one is active in the first half, a zero in the second
    assign half_active = cur_bit ^ second_half;
    assign mod_out     = !silent && half_active && sub_level;

endmodule

// File: rtl/nfcm_tx.sv
module nfcm_tx #(
    parameter int DATA_W   = 8,
    parameter int BIT_LOG2 = 7,
    parameter int SUB_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_ready,
    output logic              mod_out
);

    logic busy;
    logic silent;
    logic cur_bit;
    logic bit_last;
    logic second_half;
    logic sub_level;

    nfcm_framer #(
        .DATA_W (DATA_W)
    ) u_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (tx_valid),
        .in_data  (tx_data),
        .bit_last (bit_last),
        .in_ready (tx_ready),
        .busy     (busy),
        .silent   (silent),
        .cur_bit  (cur_bit)
    );

    nfcm_divider #(
        .BIT_LOG2 (BIT_LOG2),
        .SUB_LOG2 (SUB_LOG2)
    ) u_div (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (busy),
        .bit_last    (bit_last),
        .second_half (second_half),
        .sub_level   (sub_level)
    );

    nfcm_coder u_coder (
        .silent      (silent),
        .cur_bit     (cur_bit),
        .second_half (second_half),
        .sub_level   (sub_level),
        .mod_out     (mod_out)
    );

    // Idle with nothing offered stays quiet
    AST_IDLE_QUIET: assert property (@(negedge clk) disable iff (!rst_n)
        (tx_ready && !tx_valid && !mod_out) |=> !mod_out); // R2

    // Subcarrier only appears once the block has left idle
    AST_OUT_NEEDS_FRAME: assert property (@(negedge clk) disable iff (!rst_n)
        mod_out |-> !$past(tx_ready) || $past(mod_out) || busy); // R3

endmodule

// File: tb/nfcm_tx_test.sv
`timescale 1ns/1ps
module nfcm_tx_test;

    localparam int K_START = 0;
    localparam int K_DATA  = 1;
    localparam int K_PAR   = 2;
    localparam int K_EOF   = 3;

    logic       clk;
    logic       rst_n;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       tx_ready;
    logic       mod_out;

    int checks;
    int errors;
    bit done;

    logic [7:0] fbuf  [0:7];
    int         bkind [0:79];
    logic       bval  [0:79];
    bit         bfirst[0:79];

    nfcm_tx uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_ready (tx_ready),
        .mod_out  (mod_out)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    task automatic chk(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic exp_out(input int b, input int c);
        logic act;
        if (bkind[b] == K_EOF) return 1'b0;
        act = ((c < 64) == (bval[b] == 1'b1));
        return act && (((c >> 3) & 1) == 1);
    endfunction

    function automatic string tag_for(input int b, input int c);
        if (bkind[b] == K_EOF) return "R10";
        if ((c < 64) != (bval[b] == 1'b1)) return "R5";
        if (bkind[b] == K_START) return "R3";
        if (bkind[b] == K_PAR) return "R7";
        if (bfirst[b]) return "R9";
        return (c < 64) ? "R4" : "R6";
    endfunction

    // Sends fbuf[0..n-1] as one frame; call right after a rising edge.
    task automatic run_frame(input int n);
        int  nb;
        int  idx;
        bit  take;
        nb = 2 + 9 * n;
        bkind[0] = K_START; bval[0] = 1'b1; bfirst[0] = 0;
        for (int k = 0; k < n; k++) begin
            for (int i = 0; i < 8; i++) begin
                bkind[1 + 9*k + i]  = K_DATA;
                bval[1 + 9*k + i]   = fbuf[k][i];
                bfirst[1 + 9*k + i] = (i == 0 && k > 0);
            end
            bkind[1 + 9*k + 8]  = K_PAR;
            bval[1 + 9*k + 8]   = ~(^fbuf[k]);
            bfirst[1 + 9*k + 8] = 0;
        end
        bkind[nb-1] = K_EOF; bval[nb-1] = 1'b0; bfirst[nb-1] = 0;

        tx_valid = 1'b1;
        tx_data  = fbuf[0];
        while (tx_ready !== 1'b1) @(posedge clk);
        idx  = 0;
        take = 1;
        for (int j = 0; j < nb * 128; j++) begin
            int b;
            int c;
            @(posedge clk);
            b = j / 128;
            c = j % 128;
            chk(tag_for(b, c), mod_out, exp_out(b, c), "mod_out");
            chk("R8", tx_ready, (c == 127 && bkind[b] == K_PAR), "tx_ready");
            if (take) begin
                idx++;
                if (idx < n) begin
                    tx_data = fbuf[idx];
                end else begin
                    tx_valid = 1'b0;
                    tx_data  = 8'($urandom);
                end
                take = 0;
            end
            if (tx_ready === 1'b1 && tx_valid === 1'b1) take = 1;
        end
        @(posedge clk);
        chk("R10", mod_out, 1'b0, "idle mod_out after frame");
        chk("R10", tx_ready, 1'b1, "idle tx_ready after frame");
    endtask

    task automatic idle_quiet(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            tx_data = 8'($urandom);
            @(posedge clk);
            chk("R2", mod_out, 1'b0, "idle mod_out");
            chk("R2", tx_ready, 1'b1, "idle tx_ready");
        end
    endtask

    initial begin
        void'($urandom(32'd20251));
        checks   = 0;
        errors   = 0;
        done     = 0;
        rst_n    = 1'b0;
        tx_valid = 1'b0;
        tx_data  = 8'h00;
        repeat (3) @(posedge clk);
        chk("R1", mod_out, 1'b0, "reset mod_out");
        chk("R1", tx_ready, 1'b1, "reset tx_ready");
        rst_n = 1'b1;
        idle_quiet(100);

        // Directed corner cases
        fbuf[0] = 8'h00; run_frame(1);
        fbuf[0] = 8'hFF; run_frame(1);
        fbuf[0] = 8'h01; fbuf[1] = 8'h80; run_frame(2);
        fbuf[0] = 8'hA5; fbuf[1] = 8'h3C; fbuf[2] = 8'h00; run_frame(3);

        // Reset in the middle of a frame
        tx_valid = 1'b1;
        tx_data  = 8'h5A;
        @(posedge clk);
        tx_valid = 1'b0;
        repeat (600) @(posedge clk);
        chk("R8", tx_ready, 1'b0, "busy mid-frame");
        rst_n = 1'b0;
        @(posedge clk);
        chk("R1", mod_out, 1'b0, "mid-frame reset mod_out");
        chk("R1", tx_ready, 1'b1, "mid-frame reset tx_ready");
        rst_n = 1'b1;
        idle_quiet(50);
        fbuf[0] = 8'hC3; run_frame(1);

        // Random frames
        for (int f = 0; f < 10; f++) begin
            int n;
            n = 1 + int'($urandom % 4);
            for (int k = 0; k < n; k++) fbuf[k] = 8'($urandom);
            run_frame(n);
            idle_quiet(1 + int'($urandom % 40));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule